// File: doc/BRIEF.md
# Page-Buffered Byte Store Controller

This block sits behind a two-wire serial slave front-end and does the memory-side work of a small byte-addressed nonvolatile store. The front-end decodes the bus and hands the block single-cycle strobes: a memory address has arrived, a data byte has arrived, the master wants a byte, a STOP was seen. A write-protect level comes in alongside them. The block returns the requested byte and a busy flag.

One address pointer serves both directions. Incoming data bytes are collected in a one-page staging buffer. Only the low bits of the pointer step during a write, so a long burst wraps inside the page, and a later byte aimed at a slot overwrites the earlier one. A STOP that follows staged data starts a write cycle of fixed length, counted in system clocks. The staged bytes are copied into a register-array model of the store when that cycle ends. Reads step the whole pointer and wrap at the top of the array. A random read is done by loading an address and then requesting bytes.

Top module: `pagebuf_ctrl`

## Requirements
- R1: After reset, busy is 0, rd_data is 0 and the pointer is 0. A data byte sent with no address load lands at location 0.
- R2: An accepted addr_load copies addr_in into the pointer. An accepted rd_req puts the byte at the pointer on rd_data at the next clock edge and advances the pointer by one.
- R3: An accepted wr_strobe stages wr_data for the location the pointer names and steps only the low 4 pointer bits, which wrap from 15 to 0 within the same 16-byte page. When a slot is staged twice before commit, the later byte is kept.
- R4: An accepted stop_seen with at least one byte staged raises busy at the next edge. Busy then stays high for exactly WR_CYCLES clock cycles, and the staged bytes are in the array once busy falls.
- R5: An accepted stop_seen with no byte staged leaves busy low.
- R6: While busy is high, addr_load, wr_strobe, rd_req and stop_seen are ignored: the pointer, the buffer, the array and rd_data keep their values.
- R7: After a committed write, the pointer names the location one past the last staged byte, wrapped within the page.
- R8: Successive reads pass from location 255 to location 0.
- R9: While wp is 1, wr_strobe stages nothing and leaves the pointer unchanged, so a following STOP starts no write cycle.
- R10: An accepted addr_load or rd_req discards all staged bytes that have not been committed. When strobes coincide, addr_load takes priority, then rd_req, then wr_strobe, then stop_seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Strobe: memory address byte received |
| addr_in | input | ADDR_W | Address to load into the pointer |
| wr_strobe | input | 1 | Strobe: data byte received |
| wr_data | input | DATA_W | Received data byte |
| rd_req | input | 1 | Strobe: master requests the next byte |
| stop_seen | input | 1 | Strobe: STOP condition detected |
| wp | input | 1 | Write-protect level |
| rd_data | output | DATA_W | Byte returned for the last read request |
| busy | output | 1 | High during the internal write cycle |

## Verification
rd_data answers a read request at the very next rising edge. Busy rises at the edge that samples the STOP and falls WR_CYCLES edges later, which is also the edge at which the array takes the staged page. The bench's behavioural model advances on each rising edge from the same sampled inputs. The outputs are compared on the falling edge that follows, so every result is checked in the first cycle it is due. Pointer effects that cannot be seen directly, such as the write-end position, the ignored strobes and write protect, are checked by a later current-address read through the normal ports.

// File: rtl/pagebuf_pkg.sv
package pagebuf_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PROG = 1'b1
  } prog_state_e;
endpackage

// File: rtl/pagebuf_ptr.sv
module pagebuf_ptr #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              rd_inc,
  input  logic              wr_inc,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_n;
  logic [PAGE_W-1:0] low_n;

  always_comb begin
    low_n = ptr[PAGE_W-1:0] + 1'b1;
    ptr_n = ptr;
    if (load)        ptr_n = load_val;
    else if (rd_inc) ptr_n = ptr + 1'b1;
    else if (wr_inc) ptr_n = {ptr[ADDR_W-1:PAGE_W], low_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_n;
  end

  // R8
  rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_inc && !load && ptr == {ADDR_W{1'b1}}) |=> (ptr == '0));
  // R3
  wr_page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inc && !load && !rd_inc) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/pagebuf_stage.sv
module pagebuf_stage #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  localparam int PAGE_SZ = 1 << PAGE_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            wr_en,
  input  logic [PAGE_W-1:0]               slot,
  input  logic [DATA_W-1:0]               din,
  output logic [PAGE_SZ-1:0]              mask,
  output logic [PAGE_SZ-1:0][DATA_W-1:0]  bytes
);
  logic [PAGE_SZ-1:0] mask_n;

  always_comb begin
    mask_n = mask;
    if (clr)        mask_n = '0;
    else if (wr_en) mask_n[slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_n;
  end

  for (genvar g = 0; g < PAGE_SZ; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && !clr && (slot == PAGE_W'(g));
    always_ff @(posedge clk) begin
      if (hit) bytes[g] <= din;
    end
  end
endmodule

// File: rtl/pagebuf_array.sv
module pagebuf_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  localparam int DEPTH   = 1 << ADDR_W,
  localparam int PAGE_SZ = 1 << PAGE_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            commit,
  input  logic [ADDR_W-PAGE_W-1:0]        page,
  input  logic [PAGE_SZ-1:0]              mask,
  input  logic [PAGE_SZ-1:0][DATA_W-1:0]  bytes,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [DATA_W-1:0]               rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_SZ; i++) begin
        if (mask[i]) mem[{page, PAGE_W'(i)}] <= bytes[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/pagebuf_ctrl.sv
module pagebuf_ctrl
  import pagebuf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              stop_seen,
  input  logic              wp,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  localparam int PAGE_SZ = 1 << PAGE_W;
  localparam int TMR_W   = $clog2(WR_CYCLES + 1);

  prog_state_e st, st_n;
  logic [TMR_W-1:0] tmr, tmr_n;
  logic idle, ld_en, rd_en, wr_en, stop_en, commit;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE_SZ-1:0] mask;
  logic [PAGE_SZ-1:0][DATA_W-1:0] bytes;

  assign idle    = (st == ST_IDLE);
  assign ld_en   = idle && addr_load;
  assign rd_en   = idle && rd_req && !addr_load;
  assign wr_en   = idle && wr_strobe && !wp && !addr_load && !rd_req;
  assign stop_en = idle && stop_seen && !addr_load && !rd_req && !wr_strobe && (|mask);
  assign commit  = (st == ST_PROG) && (tmr == '0);
  assign busy    = (st == ST_PROG);

  always_comb begin
    st_n  = st;
    tmr_n = tmr;
    if (stop_en) begin
      st_n  = ST_PROG;
      tmr_n = TMR_W'(WR_CYCLES - 1);
    end else if (st == ST_PROG) begin
      if (tmr == '0) st_n = ST_IDLE;
      else           tmr_n = tmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      tmr <= '0;
    end else begin
      st  <= st_n;
      tmr <= tmr_n;
    end
  end

  pagebuf_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ld_en), .load_val(addr_in),
    .rd_inc(rd_en), .wr_inc(wr_en), .ptr(ptr)
  );

  pagebuf_stage #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .clr(ld_en || rd_en || commit), .wr_en(wr_en),
    .slot(ptr[PAGE_W-1:0]), .din(wr_data), .mask(mask), .bytes(bytes)
  );

  pagebuf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .page(ptr[ADDR_W-1:PAGE_W]),
    .mask(mask), .bytes(bytes), .rd_en(rd_en), .rd_addr(ptr), .rd_data(rd_data)
  );

  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_seen));
  // R5
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && !busy && mask == '0) |=> !busy);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ptr) && $stable(rd_data)));
  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && !busy && !addr_load && !rd_req) |=> $stable(mask));
endmodule

// File: tb/tb_pagebuf_ctrl.sv
module tb_pagebuf_ctrl;
  localparam int WR = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 0, wr_strobe = 0, rd_req = 0, stop_seen = 0, wp = 0;
  logic [7:0] addr_in = 0, wr_data = 0, rd_data;
  logic busy;
  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural model
  int mem_m [256];
  int buf_m [16];
  int ptr_m = 0, rd_m = 0, tmr_m = 0;
  bit busy_m = 0;

  pagebuf_ctrl #(.WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_req(rd_req),
    .stop_seen(stop_seen), .wp(wp), .rd_data(rd_data), .busy(busy)
  );

  always #4 clk = ~clk;

  function automatic bit any_staged();
    for (int i = 0; i < 16; i++) if (buf_m[i] >= 0) return 1;
    return 0;
  endfunction

  task automatic clear_buf();
    for (int i = 0; i < 16; i++) buf_m[i] = -1;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (busy_m) begin
        if (tmr_m == 0) begin
          for (int i = 0; i < 16; i++)
            if (buf_m[i] >= 0) mem_m[(ptr_m & 8'hF0) | i] = buf_m[i];
          clear_buf();
          busy_m = 0;
        end else tmr_m--;
      end else if (addr_load) begin
        ptr_m = addr_in; clear_buf();
      end else if (rd_req) begin
        rd_m = mem_m[ptr_m]; ptr_m = (ptr_m + 1) % 256; clear_buf();
      end else if (wr_strobe) begin
        if (!wp) begin
          buf_m[ptr_m % 16] = wr_data;
          ptr_m = (ptr_m & 8'hF0) | ((ptr_m + 1) & 8'h0F);
        end
      end else if (stop_seen && any_staged()) begin
        busy_m = 1; tmr_m = WR - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy === busy_m, "R4 busy vs model", int'(busy), int'(busy_m));
      if (rd_m >= 0) chk(rd_data === 8'(rd_m), "R2 rd_data vs model", int'(rd_data), rd_m);
    end
  end

  task automatic pulse_addr(input int a);
    addr_in = 8'(a); addr_load = 1; @(negedge clk); addr_load = 0;
  endtask
  task automatic pulse_wr(input int d);
    wr_data = 8'(d); wr_strobe = 1; @(negedge clk); wr_strobe = 0;
  endtask
  task automatic pulse_rd();
    rd_req = 1; @(negedge clk); rd_req = 0;
  endtask
  task automatic pulse_stop();
    stop_seen = 1; @(negedge clk); stop_seen = 0;
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask
  task automatic read_at(input int a, input int exp, input string req);
    pulse_addr(a); pulse_rd();
    chk(rd_data === 8'(exp), req, int'(rd_data), exp);
  endtask

  initial begin
    int n;
    for (int i = 0; i < 256; i++) mem_m[i] = -1;
    clear_buf();
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(rd_data === 8'h00, "R1 rd_data after reset", int'(rd_data), 0);
    rst_n = 1;
    @(negedge clk);
    // R1: no address load, byte goes to location 0
    pulse_wr(8'hA5); pulse_stop();
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == WR, "R4 busy length", n, WR);
    read_at(0, 8'hA5, "R1 pointer reset to 0");
    // byte write at 0x12
    pulse_addr(8'h12); pulse_wr(8'h77); pulse_stop(); wait_idle();
    // R3 page wrap burst
    pulse_addr(8'h1E);
    pulse_wr(8'h11); pulse_wr(8'h22); pulse_wr(8'h33); pulse_wr(8'h44);
    pulse_stop(); wait_idle();
    pulse_rd();
    chk(rd_data === 8'h77, "R7 pointer after write", int'(rd_data), 8'h77);
    read_at(8'h1E, 8'h11, "R3 first slot");
    pulse_rd();
    chk(rd_data === 8'h22, "R2 sequential next", int'(rd_data), 8'h22);
    read_at(8'h10, 8'h33, "R3 wrapped to page start");
    pulse_rd();
    chk(rd_data === 8'h44, "R3 wrapped second", int'(rd_data), 8'h44);
    // R3 overwrite with 17 bytes
    pulse_addr(8'h40);
    for (int i = 0; i < 17; i++) pulse_wr(i + 1);
    pulse_stop(); wait_idle();
    read_at(8'h40, 17, "R3 later byte overwrites");
    read_at(8'h41, 2, "R3 untouched slot");
    // R5 stop with nothing staged
    pulse_addr(8'h50); pulse_stop();
    chk(busy === 1'b0, "R5 no write cycle", int'(busy), 0);
    // R9 write protect
    pulse_addr(8'h40); wp = 1; pulse_wr(8'hEE); pulse_stop();
    chk(busy === 1'b0, "R9 no write cycle under wp", int'(busy), 0);
    wp = 0; pulse_rd();
    chk(rd_data === 8'd17, "R9 pointer and array unchanged", int'(rd_data), 17);
    // R6 strobes ignored while busy
    pulse_addr(8'h11); pulse_wr(8'h5A); pulse_stop();
    pulse_addr(8'h40); pulse_wr(8'h99); pulse_rd(); pulse_stop();
    chk(rd_data === 8'd17, "R6 rd_data held while busy", int'(rd_data), 17);
    wait_idle();
    pulse_rd();
    chk(rd_data === 8'h77, "R6 pointer untouched while busy", int'(rd_data), 8'h77);
    read_at(8'h11, 8'h5A, "R6 commit intact");
    // R8 wrap 255 -> 0
    pulse_addr(8'hFF); pulse_wr(8'hC3); pulse_stop(); wait_idle();
    read_at(8'hFF, 8'hC3, "R8 top byte");
    pulse_rd();
    chk(rd_data === 8'hA5, "R8 read wraps to 0", int'(rd_data), 8'hA5);
    // R10 address load discards staged byte
    pulse_addr(8'h12); pulse_wr(8'h01); pulse_addr(8'h12); pulse_stop();
    chk(busy === 1'b0, "R10 staged byte discarded", int'(busy), 0);
    pulse_rd();
    chk(rd_data === 8'h77, "R10 array unchanged", int'(rd_data), 8'h77);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule